// File: doc/BRIEF.md
# Serial Audio DAC Stream Driver

This block feeds one serial-input 16-bit audio converter that is shared between a left and a right channel. A producer hands it a stereo pair of signed 16-bit samples through a valid/ready handshake. The block then shifts the left word and the right word out, one after the other, over a three-wire port: a bit clock, a data line and a latch enable. The bit clock is derived from the system clock by a divider parameter.

Each word ends when latch enable falls, and that is the moment the converter takes the word. After each latch the block waits out a settling delay, given in system-clock cycles, and then raises a hold-stage control strobe for the channel whose word was just latched. A downstream sample/hold stage uses that strobe to connect the converter output to its own capacitor only after the output has settled. The analog hold stage, the settling itself and the filtering all lie outside this block.

Top module: `dac_stream_driver`

## Requirements
- R1: During and directly after reset, dac_bclk, dac_data, dac_le, hold_left and hold_right are 0 and in_ready is 1.
- R2: in_ready is 1 exactly when no pair is being sent. A pair is taken on a rising clock edge where in_valid and in_ready are both 1. A pair offered while in_ready is 0 is kept waiting and is sent once it is taken, never lost. in_ready is 0 at every rising bit-clock edge and when the left word latches, and it is 1 in the cycle the right word latches.
- R3: Each accepted pair is sent as the left word followed by the right word. Each word is sent in exactly 16 rising bit-clock edges, most significant bit first, and its two's-complement bits are sent unchanged.
- R4: The bit clock is high for exactly HALF_DIV system cycles and low for exactly HALF_DIV system cycles between the bits of a word. It stays low while no pair is being sent.
- R5: dac_data changes only in a cycle where dac_bclk is 0, and it has been stable for at least HALF_DIV cycles at every rising bit-clock edge.
- R6: dac_le rises when the 16th bit of a word goes onto dac_data and stays high for exactly 2*HALF_DIV cycles. It falls in the same cycle as the bit clock falls after the 16th rising edge. That falling edge is the latch point of the word.
- R7: dac_le is 0 at every rising bit-clock edge other than the 16th of a word. This includes the first edge of a word that follows a pause of the bit clock.
- R8: A hold strobe first reads 1 exactly SETTLE_CYC cycles after the first cycle in which dac_le reads 0 after a latch. It stays at 1 for exactly HOLD_CYC cycles. hold_left answers left-word latches and hold_right answers right-word latches.
- R9: hold_left and hold_right are never 1 at the same time, and both are 0 in any cycle where dac_le falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A stereo pair is offered |
| in_left | input | DATA_W | Left sample, two's complement |
| in_right | input | DATA_W | Right sample, two's complement |
| in_ready | output | 1 | Block can take a pair this cycle |
| dac_bclk | output | 1 | Serial bit clock to the converter |
| dac_data | output | 1 | Serial data, most significant bit first |
| dac_le | output | 1 | Latch enable, falling edge latches the word |
| hold_left | output | 1 | Left hold-stage connect strobe |
| hold_right | output | 1 | Right hold-stage connect strobe |

## Verification
The assertions assume that rst_n is held low for at least one clock edge before any checked cycle. They also assume that SETTLE_CYC + HOLD_CYC is shorter than one word time (16 * 2 * HALF_DIV cycles), so that one channel's strobe ends before the other channel's word latches. The stimulus keeps the default parameters, which satisfy that bound: 158 cycles against 192. It changes in_valid and the samples only on falling clock edges. It offers pairs both back to back, with valid held across whole transfers, and after idle gaps that stop the bit clock. This way both the continuous and the paused latch-enable cases are reached.

// File: rtl/dac_pkg.sv
// Shared types for the serial DAC stream driver.
// Assumes: channel order on the shared converter is left first, then right.
package dac_pkg;
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/dac_bclk_gen.sv
// Bit-clock generator: divides clk into a bit clock with HALF_DIV cycles low
// followed by HALF_DIV cycles high. It marks the last system cycle of each bit
// slot. Assumes run is held for whole slots and drops only after a slot end.
module dac_bclk_gen #(
    parameter int HALF_DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic bclk,
    output logic slot_end
);
    localparam int PERIOD = 2 * HALF_DIV;
    localparam int PW     = $clog2(PERIOD);

    logic [PW-1:0] phase;
    logic [PW-1:0] phase_nxt;

    // Next phase inside the slot, wrapping at the slot length
    always_comb begin
        phase_nxt = (phase == PW'(PERIOD - 1)) ? '0 : phase + 1'b1;
    end

    assign slot_end = run && (phase == PW'(PERIOD - 1));

    // Phase counter and registered bit clock (high in the second half of a slot)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            bclk  <= 1'b0;
        end else if (!run) begin
            phase <= '0;
            bclk  <= 1'b0;
        end else begin
            phase <= phase_nxt;
            bclk  <= (phase_nxt >= PW'(HALF_DIV));
        end
    end
endmodule

// File: rtl/dac_word_framer.sv
// Word framer: takes a stereo pair, shifts the left and then the right word out
// MSB first at slot boundaries, and frames each word with latch enable. LE rises
// as the last bit is presented and falls one full bit period later; a one-cycle
// latch pulse names the channel just latched. Assumes slot_end comes from a
// bit-clock generator that is running while busy is high.
module dac_word_framer
    import dac_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic              slot_end,
    output logic              in_ready,
    output logic              busy,
    output logic              sdata,
    output logic              le,
    output logic [NUM_CH-1:0] latch_pls
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] rbuf;
    logic [IDX_W-1:0]  bit_idx;
    chan_e             ch;

    assign in_ready = !busy;
    assign sdata    = shreg[DATA_W-1];

    // Accept a pair, shift bits at slot ends, frame LE and flag latch points
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            ch        <= CH_LEFT;
            bit_idx   <= '0;
            shreg     <= '0;
            rbuf      <= '0;
            le        <= 1'b0;
            latch_pls <= '0;
        end else begin
            latch_pls <= '0;
            if (!busy) begin
                if (in_valid) begin
                    busy    <= 1'b1;
                    shreg   <= in_left;
                    rbuf    <= in_right;
                    ch      <= CH_LEFT;
                    bit_idx <= '0;
                end
            end else if (slot_end) begin
                if (bit_idx == IDX_W'(DATA_W - 1)) begin
                    le      <= 1'b0;
                    bit_idx <= '0;
                    if (ch == CH_LEFT) begin
                        latch_pls <= 2'b01;
                        ch        <= CH_RIGHT;
                        shreg     <= rbuf;
                    end else begin
                        latch_pls <= 2'b10;
                        busy      <= 1'b0;
                    end
                end else begin
                    shreg   <= {shreg[DATA_W-2:0], 1'b0};
                    bit_idx <= bit_idx + 1'b1;
                    if (bit_idx == IDX_W'(DATA_W - 2)) begin
                        le <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dac_hold_timer.sv
// Per-channel hold-stage timer: after a latch pulse it waits SETTLE_CYC cycles
// (counted from the cycle of the pulse) and then raises its strobe for HOLD_CYC
// cycles. Assumes SETTLE_CYC >= 2, HOLD_CYC >= 1, and pulses that are further
// apart than SETTLE_CYC + HOLD_CYC.
module dac_hold_timer #(
    parameter int SETTLE_CYC = 150,
    parameter int HOLD_CYC   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic strobe
);
    localparam int TOTAL = SETTLE_CYC + HOLD_CYC;
    localparam int CW    = $clog2(TOTAL + 1);

    logic [CW-1:0] elapsed;
    logic          active;

    // Count cycles since the latch and open the strobe inside its window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed <= '0;
            active  <= 1'b0;
            strobe  <= 1'b0;
        end else if (start) begin
            elapsed <= CW'(1);
            active  <= 1'b1;
            strobe  <= 1'b0;
        end else if (active) begin
            if (elapsed == CW'(TOTAL - 1)) begin
                elapsed <= '0;
                active  <= 1'b0;
                strobe  <= 1'b0;
            end else begin
                elapsed <= elapsed + 1'b1;
                strobe  <= ((elapsed + 1'b1) >= CW'(SETTLE_CYC));
            end
        end
    end
endmodule

// File: rtl/dac_stream_driver.sv
// Serial audio DAC stream driver: time-shares one serial converter between a
// left and a right channel. It takes stereo pairs on a valid/ready handshake,
// sends each word over bit clock, data and latch enable, and after each latch
// gives a delayed hold-stage strobe for the channel just latched.
// Assumes: HALF_DIV meets the converter's high/low time at the clk rate, and
// SETTLE_CYC + HOLD_CYC is less than one word time (16 * 2 * HALF_DIV).
module dac_stream_driver
    import dac_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int HALF_DIV   = 6,
    parameter int SETTLE_CYC = 150,
    parameter int HOLD_CYC   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    output logic              in_ready,
    output logic              dac_bclk,
    output logic              dac_data,
    output logic              dac_le,
    output logic              hold_left,
    output logic              hold_right
);
    logic              busy;
    logic              slot_end;
    logic [NUM_CH-1:0] latch_pls;
    logic [NUM_CH-1:0] hold_vec;

    dac_bclk_gen #(
        .HALF_DIV (HALF_DIV)
    ) u_bclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .bclk     (dac_bclk),
        .slot_end (slot_end)
    );

    dac_word_framer #(
        .DATA_W (DATA_W)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_left   (in_left),
        .in_right  (in_right),
        .slot_end  (slot_end),
        .in_ready  (in_ready),
        .busy      (busy),
        .sdata     (dac_data),
        .le        (dac_le),
        .latch_pls (latch_pls)
    );

    // One hold-stage timer per channel sharing the converter
    for (genvar g = 0; g < NUM_CH; g++) begin : g_hold
        dac_hold_timer #(
            .SETTLE_CYC (SETTLE_CYC),
            .HOLD_CYC   (HOLD_CYC)
        ) u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (latch_pls[g]),
            .strobe (hold_vec[g])
        );
    end

    assign hold_left  = hold_vec[CH_LEFT];
    assign hold_right = hold_vec[CH_RIGHT];
endmodule

// File: rtl/dac_stream_driver_chk.sv
// Protocol checker for dac_stream_driver, bound to every instance of it.
// Assumes reset is applied at time zero.
module dac_stream_driver_chk #(
    parameter int SETTLE_CYC = 150
) (
    input logic clk,
    input logic rst_n,
    input logic in_ready,
    input logic dac_bclk,
    input logic dac_data,
    input logic dac_le,
    input logic hold_left,
    input logic hold_right
);
    localparam int CW = $clog2(SETTLE_CYC + 2) + 1;

    logic          le_d;
    logic [CW-1:0] since_latch;

    // Track cycles since the last latch-enable fall, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            le_d        <= 1'b0;
            since_latch <= '0;
        end else begin
            le_d <= dac_le;
            if (le_d && !dac_le) begin
                since_latch <= CW'(1);
            end else if (since_latch != '1) begin
                since_latch <= since_latch + 1'b1;
            end
        end
    end

    // R4
    bclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !dac_bclk);

    // R5
    data_stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_bclk) |-> $stable(dac_data));

    // R5
    data_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_data) |-> !dac_bclk);

    // R6
    le_fall_on_bclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_le) |-> $fell(dac_bclk));

    // R2
    ready_low_during_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_le |-> !in_ready);

    // R9
    single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_left && hold_right));

    // R9
    hold_clear_at_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_le) |-> (!hold_left && !hold_right));

    // R8
    hold_left_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_left) |-> (since_latch == CW'(SETTLE_CYC)));

    // R8
    hold_right_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_right) |-> (since_latch == CW'(SETTLE_CYC)));
endmodule

bind dac_stream_driver dac_stream_driver_chk #(
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .dac_bclk   (dac_bclk),
    .dac_data   (dac_data),
    .dac_le     (dac_le),
    .hold_left  (hold_left),
    .hold_right (hold_right)
);

// File: tb/dac_stream_driver_test.sv
// Scoreboard bench: the driver pushes {channel, word} items when a pair is
// taken, and the monitor decodes the serial port and pops and compares them.
module dac_stream_driver_test;
    localparam int W      = 16;
    localparam int HALF   = 6;
    localparam int SETTLE = 150;
    localparam int HOLDW  = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_left = '0;
    logic [W-1:0] in_right = '0;
    logic         in_ready, dac_bclk, dac_data, dac_le, hold_left, hold_right;

    int vectors = 0;
    int fails   = 0;
    int pairs   = 0;
    int holds   = 0;
    logic [W:0] expq[$];

    always #10 clk = ~clk;

    dac_stream_driver #(
        .DATA_W (W), .HALF_DIV (HALF), .SETTLE_CYC (SETTLE), .HOLD_CYC (HOLDW)
    ) uut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_left (in_left),
        .in_right (in_right), .in_ready (in_ready), .dac_bclk (dac_bclk),
        .dac_data (dac_data), .dac_le (dac_le), .hold_left (hold_left),
        .hold_right (hold_right)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: offer a pair from a falling edge and wait until it is taken (R2)
    task automatic send_pair(input logic [W-1:0] l, input logic [W-1:0] r);
        in_valid = 1'b1;
        in_left  = l;
        in_right = r;
        while (!in_ready) @(negedge clk);
        expq.push_back({1'b0, l});
        expq.push_back({1'b1, r});
        pairs++;
        @(negedge clk);
        in_valid = 1'b0;
        in_left  = ~l;
        in_right = ~r;
    endtask

    // Monitor state
    int cyc = 0;
    int stable_cnt = 0, hi_run = 0, lo_run = 0, le_run = 0, bitcnt = 0;
    logic prev_bclk = 1'b0, prev_le = 1'b0, prev_data = 1'b0;
    logic [W-1:0] shift = '0;
    logic last_ch = 1'b1;
    int exp_rise[2] = '{-1, -1};
    int start_h[2]  = '{0, 0};
    logic prev_h[2] = '{1'b0, 1'b0};

    always @(negedge clk) begin
        if (rst_n) begin
            logic hv[2];
            logic [W:0] item;
            hv[0] = hold_left;
            hv[1] = hold_right;
            cyc++;
            if (dac_data != prev_data) begin
                chk(dac_bclk == 1'b0, "R5 data change while bclk high", dac_bclk, 0);
                stable_cnt = 0;
            end else begin
                stable_cnt++;
            end
            if (dac_bclk && !prev_bclk) begin
                chk(stable_cnt >= HALF, "R5 setup before rise", stable_cnt, HALF);
                if (bitcnt > 0) chk(lo_run == HALF, "R4 low time", lo_run, HALF);
                chk(dac_le == (bitcnt == W - 1), "R7 le at rising edge", dac_le, bitcnt == W - 1);
                chk(in_ready == 1'b0, "R2 ready low while sending", in_ready, 0);
                shift = {shift[W-2:0], dac_data};
                bitcnt++;
            end
            if (!dac_bclk && prev_bclk) chk(hi_run == HALF, "R4 high time", hi_run, HALF);
            if (dac_bclk) hi_run = (prev_bclk ? hi_run : 0) + 1;
            else          lo_run = (!prev_bclk ? lo_run : 0) + 1;
            if (!dac_bclk && !in_ready == 1'b0) chk(1'b1, "R4", 0, 0);
            if (in_ready) chk(dac_bclk == 1'b0, "R4 idle bclk low", dac_bclk, 0);
            if (dac_le) le_run = (prev_le ? le_run : 0) + 1;
            if (!dac_le && prev_le) begin
                chk(le_run == 2 * HALF, "R6 le high time", le_run, 2 * HALF);
                chk(!dac_bclk && prev_bclk, "R6 le falls with bclk", dac_bclk, 0);
                chk(bitcnt == W, "R3 bits per word", bitcnt, W);
                chk(!hold_left && !hold_right, "R9 strobes clear at latch", {hold_left, hold_right}, 0);
                if (expq.size() == 0) begin
                    chk(1'b0, "R3 unexpected word", shift, 0);
                end else begin
                    item = expq.pop_front();
                    chk(shift == item[W-1:0], "R3 word value", shift, item[W-1:0]);
                    chk(item[W] != last_ch, "R3 channel order", item[W], !last_ch);
                    chk(in_ready == item[W], "R2 ready at latch", in_ready, item[W]);
                    last_ch = item[W];
                    exp_rise[item[W]] = cyc + SETTLE;
                end
                bitcnt = 0;
            end
            for (int c = 0; c < 2; c++) begin
                if (hv[c] && !prev_h[c]) begin
                    chk(cyc == exp_rise[c], "R8 strobe delay", cyc, exp_rise[c]);
                    start_h[c] = cyc;
                    holds++;
                end
                if (!hv[c] && prev_h[c]) chk(cyc - start_h[c] == HOLDW, "R8 strobe width", cyc - start_h[c], HOLDW);
            end
            chk(!(hold_left && hold_right), "R9 one strobe at a time", {hold_left, hold_right}, 0);
            prev_bclk = dac_bclk;
            prev_le   = dac_le;
            prev_data = dac_data;
            prev_h[0] = hv[0];
            prev_h[1] = hv[1];
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (60000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dac_bclk == 0 && dac_data == 0 && dac_le == 0, "R1 port outputs in reset",
            {dac_bclk, dac_data, dac_le}, 0);
        chk(hold_left == 0 && hold_right == 0, "R1 strobes in reset", {hold_left, hold_right}, 0);
        chk(in_ready == 1, "R1 ready in reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1 && dac_bclk == 0 && dac_le == 0, "R1 state after reset",
            {in_ready, dac_bclk, dac_le}, 3'b100);
        // Full-scale and zero-crossing codes (R3)
        send_pair(16'h7FFF, 16'h8000);
        send_pair(16'h0000, 16'hFFFF);
        repeat (40) @(negedge clk);
        // Pause of the bit clock before the next word (R7)
        send_pair(16'hA5A5, 16'h5A5A);
        repeat (SETTLE + 30) @(negedge clk);
        // Back-to-back pairs with valid held across transfers (R2)
        for (int i = 0; i < 6; i++) begin
            send_pair(16'(16'h1357 * (i + 3)) ^ 16'(i << 12), 16'(16'hC0DE + 16'h0F1 * i));
        end
        repeat (17) @(negedge clk);
        send_pair(16'h0001, 16'hFFFE);
        while (expq.size() != 0) @(negedge clk);
        repeat (SETTLE + HOLDW + 20) @(negedge clk);
        chk(holds == 2 * pairs, "R8 strobe count", holds, 2 * pairs);
        chk(in_ready == 1 && dac_bclk == 0, "R4 idle after last pair", {in_ready, dac_bclk}, 2'b10);
        finish_run();
    end
endmodule